// File: doc/BRIEF.md
# Priority-Based Pin Function Resolver

This block decides, for each of six multi-function pads, which signal source drives the pad. It keeps four writable 32-bit control words and exposes one read-only strap word that comes from an input port. All five words can be read over a simple word-wide bus, and the control words can be written over it.

Each pad has an ordered list of priority levels. Level 0 has the highest priority. A level can be enabled by several alternative expressions. An expression is a conjunction of masked-field comparisons. Each comparison takes a field of a control word or of the strap word and tests it for equality or inequality against a value aligned to bit 0. The field position comes from the lowest set bit of its mask. The highest enabled level wins. When no level is enabled, the pad falls back to its "other" source.

Resolution is purely combinational from the stored words. A bus write therefore shows on the pad selects one clock edge after it is presented.

Top module: `pin_func_resolver`

## Requirements
- R1: After reset all four control words read as zero. With strap bit 19 set, every pad then reports the fallback select.
- R2: A write with bus_we high to byte offset 0x00, 0x04, 0x08 or 0x0C stores bus_wdata in control word 0, 1, 2 or 3 at the next rising clock edge. A later read of that offset returns it.
- R3: A read of offset 0x10 returns strap_i. A write to 0x10 changes no stored word and no pad select.
- R4: Reads of misaligned offsets or offsets above 0x10 return zero. Writes to such offsets change no stored word.
- R5: Every pad field pad_sel_o[2p+1:2p] holds the winning level index: 0 for the top level, 1 for the second level. It holds 2 for the fallback. pad_hit_o[p] is 1 exactly when a non-fallback level won.
- R6: Pad 0 selects level 0 when control word 0 bit 0 is 1.
- R7: Pad 1 selects level 0 when word 2 bit 22 is 1, regardless of word 0 bit 4. Otherwise it selects level 1 when word 0 bit 4 is 1.
- R8: Pad 2 needs word 1 bit 3 and word 0 bit 15 both set; if either is clear it falls back. With both set, it picks level 0 when word 2 bit 31 is 0 and level 1 when that bit is 1.
- R9: Word 2 bits [5:4] form a mode field. Pad 3 selects level 0 when the mode is nonzero and word 0 bit 17 is 1. Pad 3 selects level 1 when word 0 bit 17 is 1 and the mode is 0.
- R10: Pad 4 selects level 0 only when the mode field equals 3 and word 0 bit 22 is 1. It selects level 1 when word 0 bit 22 is 1 and the mode is any other value.
- R11: Pad 5 selects level 0 when word 0 bit 25 is 1. Otherwise it selects level 1 when word 3 bit 12 is 1 or strap bit 19 is 0. With strap bit 19 at 0, no bus write to word 3 can make it fall back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current bus cycle |
| bus_addr | input | 8 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| strap_i | input | 32 | Read-only strap word |
| pad_sel_o | output | 12 | Per-pad 2-bit winning level, pad p at bits [2p+1:2p] |
| pad_hit_o | output | 6 | Per-pad flag, 1 when a non-fallback level won |

## Verification
If a control word is corrupted, a wrong mask shift is applied, or the priority order is wrong, the error shows on pad_sel_o and pad_hit_o in the same cycle the stored word takes effect. That is one clock edge after the offending write. The same corruption also shows on bus_rdata at the next read of that offset. A reference model in the bench mirrors every write and the strap value. After every write, every pad's select is compared against the model, so a fault is seen at the first vector that exercises the broken term. Directed cases cover cases that random data hits rarely: the mode field equal to exactly 3, the third bit of pad 2 changing between its two levels, and the strap keeping pad 5 on a bus-independent level.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  localparam int DW         = 32;
  localparam int AW         = 8;
  localparam int NUM_CTL    = 4;
  localparam int NUM_PADS   = 6;
  localparam int NUM_LEVELS = 2;
  localparam int NUM_EXPRS  = 2;
  localparam int NUM_TERMS  = 3;
  localparam int SELW       = $clog2(NUM_LEVELS + 1);
  localparam int CTLW       = $clog2(NUM_CTL);
  localparam int SRC_STRAP  = NUM_CTL;

  typedef struct packed {
    logic          used;
    logic          ne;
    logic [2:0]    src;
    logic [DW-1:0] mask;
    logic [DW-1:0] val;
  } term_t;

  function automatic term_t bit_term(int src, int idx, logic en);
    term_t r;
    r.used = 1'b1;
    r.ne   = 1'b0;
    r.src  = 3'(src);
    r.mask = DW'(1) << idx;
    r.val  = DW'(en);
    return r;
  endfunction

  function automatic term_t fld_term(int src, logic [DW-1:0] mask, logic [DW-1:0] val, logic ne);
    term_t r;
    r.used = 1'b1;
    r.ne   = ne;
    r.src  = 3'(src);
    r.mask = mask;
    r.val  = val;
    return r;
  endfunction

  function automatic int low_bit(logic [DW-1:0] mask);
    for (int i = DW - 1; i >= 0; i--) begin
      if (mask[i]) low_bit = i;
    end
    if (mask == '0) low_bit = 0;
  endfunction

  // Expression table: pad, level, alternative expression, conjunct term.
  function automatic term_t term_at(int p, int l, int e, int t);
    term_t r;
    r = '0;
    case (p)
      0: if (l == 0 && e == 0 && t == 0) r = bit_term(0, 0, 1'b1);
      1: begin
        if (l == 0 && e == 0 && t == 0) r = bit_term(2, 22, 1'b1);
        if (l == 1 && e == 0 && t == 0) r = bit_term(0, 4, 1'b1);
      end
      2: if (e == 0) begin
        if (t == 0) r = bit_term(1, 3, 1'b1);
        if (t == 1) r = bit_term(0, 15, 1'b1);
        if (t == 2) r = bit_term(2, 31, (l == 1));
      end
      3: if (e == 0) begin
        if (t == 0) r = bit_term(0, 17, 1'b1);
        if (l == 0 && t == 1) r = fld_term(2, 32'h30, 32'h0, 1'b1);
      end
      4: if (e == 0) begin
        if (t == 0) r = bit_term(0, 22, 1'b1);
        if (l == 0 && t == 1) r = fld_term(2, 32'h30, 32'h3, 1'b0);
      end
      5: begin
        if (l == 0 && e == 0 && t == 0) r = bit_term(0, 25, 1'b1);
        if (l == 1 && e == 0 && t == 0) r = bit_term(3, 12, 1'b1);
        if (l == 1 && e == 1 && t == 0) r = bit_term(SRC_STRAP, 19, 1'b0);
      end
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pfr_regbank.sv
module pfr_regbank
  import pfr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_we,
  input  logic [AW-1:0]                 bus_addr,
  input  logic [DW-1:0]                 bus_wdata,
  output logic [DW-1:0]                 bus_rdata,
  input  logic [DW-1:0]                 strap_i,
  output logic [NUM_CTL:0][DW-1:0]      src_o
);
  logic [NUM_CTL-1:0][DW-1:0] ctl_q, ctl_d;
  logic [NUM_CTL-1:0]         ctl_en;
  logic [AW-3:0]              word_idx;
  logic                       aligned;
  logic                       wr_hit;
  logic [CTLW-1:0]            wr_sel;

  assign word_idx = bus_addr[AW-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign wr_hit   = bus_we && aligned && (int'(word_idx) < NUM_CTL);
  assign wr_sel   = word_idx[CTLW-1:0];

  for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
    assign ctl_en[k] = wr_hit && (int'(wr_sel) == k);
    assign ctl_d[k]  = ctl_en[k] ? bus_wdata : ctl_q[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ctl_q[k] <= '0;
      else if (ctl_en[k]) ctl_q[k] <= ctl_d[k];
    end

    assign src_o[k] = ctl_q[k];
  end
  assign src_o[SRC_STRAP] = strap_i;

  always_comb begin
    bus_rdata = '0;
    if (aligned && int'(word_idx) < NUM_CTL)       bus_rdata = ctl_q[wr_sel];
    else if (aligned && int'(word_idx) == NUM_CTL) bus_rdata = strap_i;
  end

  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (ctl_q[$past(wr_sel)] == $past(bus_wdata)));
  // R4
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(ctl_q));
  // R3
  strap_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(4 * NUM_CTL)) |-> (bus_rdata == strap_i));
  // R4
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!aligned || int'(word_idx) > NUM_CTL) |-> (bus_rdata == '0));
endmodule

// File: rtl/pfr_pad_eval.sv
module pfr_pad_eval
  import pfr_pkg::*;
#(
  parameter int PAD = 0
) (
  input  logic [NUM_CTL:0][DW-1:0] src_i,
  output logic [NUM_LEVELS-1:0]    lvl_act_o
);
  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    logic [NUM_EXPRS-1:0] expr_true;

    for (genvar e = 0; e < NUM_EXPRS; e++) begin : g_expr
      localparam term_t HEAD = term_at(PAD, l, e, 0);
      logic [NUM_TERMS-1:0] term_ok;

      for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
        localparam term_t TM = term_at(PAD, l, e, t);
        localparam int    SH = low_bit(TM.mask);
        if (TM.used) begin : g_used
          logic [DW-1:0] fld;
          assign fld = (src_i[TM.src] & TM.mask) >> SH;
          if (TM.ne) begin : g_ne
            assign term_ok[t] = (fld != TM.val);
          end else begin : g_eq
            assign term_ok[t] = (fld == TM.val);
          end
        end else begin : g_idle
          assign term_ok[t] = 1'b1;
        end
      end

      assign expr_true[e] = HEAD.used && (&term_ok);
    end

    assign lvl_act_o[l] = |expr_true;
  end
endmodule

// File: rtl/pfr_prio.sv
module pfr_prio
  import pfr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] lvl_act_i,
  output logic [SELW-1:0]       sel_o,
  output logic                  hit_o
);
  always_comb begin
    sel_o = SELW'(NUM_LEVELS);
    hit_o = 1'b0;
    for (int l = NUM_LEVELS - 1; l >= 0; l--) begin
      if (lvl_act_i[l]) begin
        sel_o = SELW'(l);
        hit_o = 1'b1;
      end
    end
  end

  // R5
  fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (lvl_act_i == '0 && sel_o == SELW'(NUM_LEVELS)));
  // R5
  winner_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (lvl_act_i[sel_o] &&
               ((lvl_act_i & ((NUM_LEVELS'(1) << sel_o) - NUM_LEVELS'(1))) == '0)));
endmodule

// File: rtl/pin_func_resolver.sv
module pin_func_resolver
  import pfr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_we,
  input  logic [AW-1:0]            bus_addr,
  input  logic [DW-1:0]            bus_wdata,
  output logic [DW-1:0]            bus_rdata,
  input  logic [DW-1:0]            strap_i,
  output logic [NUM_PADS*SELW-1:0] pad_sel_o,
  output logic [NUM_PADS-1:0]      pad_hit_o
);
  logic [NUM_CTL:0][DW-1:0] src;

  pfr_regbank u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .strap_i   (strap_i),
    .src_o     (src)
  );

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic [NUM_LEVELS-1:0] lvl_act;

    pfr_pad_eval #(.PAD(p)) u_eval (
      .src_i     (src),
      .lvl_act_o (lvl_act)
    );

    pfr_prio u_prio (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_act_i (lvl_act),
      .sel_o     (pad_sel_o[p*SELW +: SELW]),
      .hit_o     (pad_hit_o[p])
    );
  end

  // R11
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strap_i[19] && !src[0][25]) |-> (pad_sel_o[5*SELW +: SELW] == SELW'(1)));
  // R8
  three_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!src[1][3] || !src[0][15]) |-> !pad_hit_o[2]);
endmodule

// File: tb/tb_pin_func_resolver.sv
module tb_pin_func_resolver;
  import pfr_pkg::*;

  logic                     clk = 1'b0;
  logic                     rst_n;
  logic                     bus_we;
  logic [AW-1:0]            bus_addr;
  logic [DW-1:0]            bus_wdata;
  logic [DW-1:0]            bus_rdata;
  logic [DW-1:0]            strap_i;
  logic [NUM_PADS*SELW-1:0] pad_sel_o;
  logic [NUM_PADS-1:0]      pad_hit_o;

  logic [DW-1:0] shadow [NUM_CTL];
  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  pin_func_resolver dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .strap_i   (strap_i),
    .pad_sel_o (pad_sel_o),
    .pad_hit_o (pad_hit_o)
  );

  function automatic int ref_sel(int p);
    logic [DW-1:0] c0, c1, c2, c3;
    c0 = shadow[0]; c1 = shadow[1]; c2 = shadow[2]; c3 = shadow[3];
    case (p)
      0: return c0[0] ? 0 : 2;
      1: return c2[22] ? 0 : (c0[4] ? 1 : 2);
      2: return !(c1[3] && c0[15]) ? 2 : (c2[31] ? 1 : 0);
      3: return !c0[17] ? 2 : ((c2[5:4] != 2'b00) ? 0 : 1);
      4: return !c0[22] ? 2 : ((c2[5:4] == 2'b11) ? 0 : 1);
      default: return c0[25] ? 0 : ((c3[12] || !strap_i[19]) ? 1 : 2);
    endcase
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_pads(string req);
    for (int p = 0; p < NUM_PADS; p++) begin
      int s;
      s = ref_sel(p);
      chk(req, DW'(pad_sel_o[p*SELW +: SELW]), DW'(s));
      chk(req, DW'(pad_hit_o[p]), DW'(s != NUM_LEVELS));
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    if (a[1:0] == 2'b00 && int'(a[AW-1:2]) < NUM_CTL) shadow[a[AW-1:2]] = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a, logic [DW-1:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    strap_i = 32'h0008_0000;
    for (int k = 0; k < NUM_CTL; k++) shadow[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int k = 0; k < NUM_CTL; k++) rd_chk("R1", AW'(4 * k), '0);
    check_pads("R1");
    for (int p = 0; p < NUM_PADS; p++) chk("R1", DW'(pad_sel_o[p*SELW +: SELW]), 2);

    // R2 readback
    wr(8'h00, 32'hA5A5_0001); wr(8'h04, 32'h1234_5678);
    wr(8'h08, 32'h0000_0000); wr(8'h0C, 32'hFFFF_EFFF);
    rd_chk("R2", 8'h00, 32'hA5A5_0001); rd_chk("R2", 8'h04, 32'h1234_5678);
    rd_chk("R2", 8'h0C, 32'hFFFF_EFFF);

    // R3 strap read and ignored write
    rd_chk("R3", 8'h10, strap_i);
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk("R3", 8'h10, strap_i);
    rd_chk("R3", 8'h00, shadow[0]);
    check_pads("R3");

    // R4 unmapped and misaligned
    wr(8'h01, 32'hDEAD_BEEF); wr(8'h14, 32'hDEAD_BEEF); wr(8'hFC, 32'hDEAD_BEEF);
    rd_chk("R4", 8'h00, shadow[0]); rd_chk("R4", 8'h04, shadow[1]);
    rd_chk("R4", 8'h14, '0); rd_chk("R4", 8'h02, '0); rd_chk("R4", 8'hFC, '0);

    // R6 pad 0
    wr(8'h00, 32'h0000_0001); check_pads("R6");
    chk("R6", DW'(pad_sel_o[1:0]), 0);

    // R7 pad 1 priority
    wr(8'h00, 32'h0000_0010); wr(8'h08, 32'h0040_0000); check_pads("R7");
    chk("R7", DW'(pad_sel_o[3:2]), 0);
    wr(8'h08, 32'h0); check_pads("R7");
    chk("R7", DW'(pad_sel_o[3:2]), 1);

    // R8 pad 2 three-bit AND
    wr(8'h04, 32'h8); wr(8'h00, 32'h8000); check_pads("R8");
    chk("R8", DW'(pad_sel_o[5:4]), 0);
    wr(8'h08, 32'h8000_0000); check_pads("R8");
    chk("R8", DW'(pad_sel_o[5:4]), 1);
    wr(8'h04, 32'h0); check_pads("R8");
    chk("R8", DW'(pad_hit_o[2]), 0);

    // R9 and R10 mode field
    for (int m = 0; m < 4; m++) begin
      wr(8'h00, 32'h0042_0000); wr(8'h08, DW'(m) << 4);
      check_pads("R9");
      chk("R9", DW'(pad_sel_o[7:6]), (m != 0) ? 0 : 1);
      chk("R10", DW'(pad_sel_o[9:8]), (m == 3) ? 0 : 1);
    end

    // R11 strap keeps pad 5 on level 1
    wr(8'h00, 32'h0); wr(8'h0C, 32'h0);
    chk("R11", DW'(pad_sel_o[11:10]), 2);
    strap_i = 32'h0; #1;
    check_pads("R11");
    chk("R11", DW'(pad_sel_o[11:10]), 1);
    wr(8'h0C, 32'h0); wr(8'h0C, 32'hFFFF_FFFF); wr(8'h0C, 32'h0);
    chk("R11", DW'(pad_sel_o[11:10]), 1);
    wr(8'h00, 32'h0200_0000);
    chk("R11", DW'(pad_sel_o[11:10]), 0);

    // R5 random mix against the reference model
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      a = AW'(4 * ($urandom % (NUM_CTL + 1)));
      if ($urandom % 8 == 0) strap_i = $urandom;
      wr(a, $urandom);
      check_pads("R5");
      rd_chk("R2", a, (int'(a[AW-1:2]) < NUM_CTL) ? shadow[a[AW-1:2]] : strap_i);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule